// File: doc/BRIEF.md
# Banked Vector Register Index Sequencer

This block turns one short-vector floating-point operation into a stream of per-element register indices. It takes the destination register number and two operand register numbers (each 5 bits), together with a length field, a stride field and a precision select. It first decides whether the operation is scalar, mixed (one operand fixed, the rest stepping) or a full vector operation. After that it emits the physical register indices for the destination and both operands, one element per accepted cycle.

Registers are grouped in banks: eight per bank for single precision and four per bank for double precision. An element index that steps past the end of its bank wraps back to the first register of the same bank. A configuration whose span cannot fit in one bank, or that uses a reserved stride code, is flagged as illegal and produces no elements. The datapath throttles the stream with a ready input. The arithmetic and the register-file storage sit outside this block.

Top module: `vrs_index_seq`

## Requirements
- R1: After reset, elem_valid, elem_last and cfg_illegal are 0, op_mode is 00 (scalar), and idx_d, idx_n and idx_m are all 0.
- R2: A register's bank number is its register number divided by 8 (single, dbl_sel=0) or by 4 (double, dbl_sel=1). A bank number whose value mod 4 is 0 is a scalar bank. If len_cfg is 0, or if rd_num lies in a scalar bank, op_mode is 00 and exactly one element is issued, with elem_last=1 and indices equal to rd_num, rn_num and rm_num.
- R3: If len_cfg is nonzero, rm_num lies in a scalar bank and rd_num does not, op_mode is 01. idx_m stays at rm_num for every element while idx_d and idx_n step.
- R4: If len_cfg is nonzero and neither rd_num nor rm_num lies in a scalar bank, op_mode is 10 and all three indices step together.
- R5: A non-scalar operation issues len_cfg+1 elements. elem_last is 1 on the final element only.
- R6: stride_cfg 00 steps by 1 and stride_cfg 11 steps by 2. Element i of a vector based at register b is (b with its in-bank bits replaced by (b + i*stride) mod bank size). For example, s13 with six elements gives 13,14,15,8,9,10, and s9 with stride 2 gives 9,11,13,15.
- R7: In double precision the bank size is 4 and wrapping happens within four registers; for example, d5 with four elements gives 5,6,7,4.
- R8: A non-scalar operation with stride_cfg 01 or 10, or with (len_cfg+1)*stride larger than the bank size, pulses cfg_illegal for one cycle (the cycle after start) and issues no element. A scalar operation with any stride code is legal.
- R9: While elem_valid is 1 and ready is 0, elem_valid and all three indices hold their values.
- R10: A start pulse while elements are still being issued is ignored: the current sequence, its indices and op_mode continue unchanged.
- R11: The first element appears on the cycle after start is sampled. elem_valid falls on the cycle after the final element is accepted with ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_cfg | input | 3 | Element count minus one |
| stride_cfg | input | 2 | Stride code: 00 one, 11 two, others reserved |
| dbl_sel | input | 1 | 1 selects double-precision register banks |
| rd_num | input | 5 | Destination register number |
| rn_num | input | 5 | First operand register number |
| rm_num | input | 5 | Second operand register number |
| start | input | 1 | Begin an operation (taken only when idle) |
| ready | input | 1 | Datapath accepts the current element |
| idx_d | output | 5 | Destination index of the current element |
| idx_n | output | 5 | First operand index of the current element |
| idx_m | output | 5 | Second operand index of the current element |
| elem_valid | output | 1 | Current element indices are valid |
| elem_last | output | 1 | Current element is the final one |
| op_mode | output | 2 | 00 scalar, 01 mixed, 10 vector |
| cfg_illegal | output | 1 | One-cycle pulse for a rejected configuration |

## Verification
The stepping logic is driven with vectors that start mid-bank so that they wrap, and with stride-two vectors from both even and odd bases. Double-precision vectors are also used, because they wrap at four rather than eight and so tell the two bank sizes apart. The mode decode is probed with a zero length field, with a destination in a scalar bank (including double bank 4) and with an operand in a scalar bank, which separates the scalar, mixed and vector paths. Illegal spans and reserved strides are checked against a scalar operation carrying a reserved stride. A stalled run with a stray start shows that backpressure and the busy condition keep the stream intact.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [1:0] {
    MODE_SCALAR = 2'b00,
    MODE_MIXED  = 2'b01,
    MODE_VECTOR = 2'b10
  } op_mode_e;

  localparam logic [1:0] STRIDE_ONE = 2'b00;
  localparam logic [1:0] STRIDE_TWO = 2'b11;
endpackage

// File: rtl/vrs_decode.sv
module vrs_decode
  import vrs_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int LEN_W  = 3,
  parameter int SP_LG  = 3,
  parameter int DP_LG  = 2
) (
  input  logic [LEN_W-1:0] len_cfg,
  input  logic [1:0]       stride_cfg,
  input  logic             dbl_sel,
  input  logic [REG_W-1:0] rd_num,
  input  logic [REG_W-1:0] rm_num,
  output op_mode_e         mode,
  output logic             illegal,
  output logic [LEN_W-1:0] last_idx,
  output logic             step_two
);
  localparam int SPAN_W = LEN_W + 2;

  function automatic logic in_scalar_bank(input logic [REG_W-1:0] num, input logic dbl);
    logic [REG_W-1:0] bank;
    bank = dbl ? (num >> DP_LG) : (num >> SP_LG);
    return bank[1:0] == 2'b00;
  endfunction

  logic              d_scalar, m_scalar;
  logic              stride_rsvd;
  logic [SPAN_W-1:0] len_ext, span, bank_sz;

  always_comb begin
    d_scalar    = in_scalar_bank(rd_num, dbl_sel);
    m_scalar    = in_scalar_bank(rm_num, dbl_sel);
    stride_rsvd = stride_cfg[1] ^ stride_cfg[0];
    step_two    = (stride_cfg == STRIDE_TWO);
    len_ext     = SPAN_W'(len_cfg) + SPAN_W'(1);
    span        = step_two ? (len_ext << 1) : len_ext;
    bank_sz     = dbl_sel ? (SPAN_W'(1) << DP_LG) : (SPAN_W'(1) << SP_LG);

    if (len_cfg == '0 || d_scalar) mode = MODE_SCALAR;
    else if (m_scalar)             mode = MODE_MIXED;
    else                           mode = MODE_VECTOR;

    illegal  = (mode != MODE_SCALAR) && (stride_rsvd || (span > bank_sz));
    last_idx = (mode == MODE_SCALAR) ? '0 : len_cfg;
  end
endmodule

// File: rtl/vrs_index_step.sv
module vrs_index_step #(
  parameter int REG_W = 5,
  parameter int SP_LG = 3,
  parameter int DP_LG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic             dbl,
  input  logic             step_two,
  input  logic [REG_W-1:0] start_num,
  output logic [REG_W-1:0] idx
);
  localparam logic [REG_W-1:0] SP_MASK = REG_W'((1 << SP_LG) - 1);
  localparam logic [REG_W-1:0] DP_MASK = REG_W'((1 << DP_LG) - 1);

  logic [REG_W-1:0] mask, step_val, nxt;

  always_comb begin
    mask     = dbl ? DP_MASK : SP_MASK;
    step_val = step_two ? REG_W'(2) : REG_W'(1);
    nxt      = (idx & ~mask) | ((idx + step_val) & mask);
  end

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= start_num;
    else if (adv)  idx <= nxt;
  end

  // R6
  bank_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((idx & ~mask) == ($past(idx) & ~mask)));
endmodule

// File: rtl/vrs_index_seq.sv
module vrs_index_seq
  import vrs_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int LEN_W      = 3,
  parameter int SP_BANK_LG = 3,
  parameter int DP_BANK_LG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic [1:0]       stride_cfg,
  input  logic             dbl_sel,
  input  logic [REG_W-1:0] rd_num,
  input  logic [REG_W-1:0] rn_num,
  input  logic [REG_W-1:0] rm_num,
  input  logic             start,
  input  logic             ready,
  output logic [REG_W-1:0] idx_d,
  output logic [REG_W-1:0] idx_n,
  output logic [REG_W-1:0] idx_m,
  output logic             elem_valid,
  output logic             elem_last,
  output logic [1:0]       op_mode,
  output logic             cfg_illegal
);
  localparam int N_IDX = 3;

  op_mode_e         dec_mode, mode_q;
  logic             dec_illegal, dec_step_two;
  logic [LEN_W-1:0] dec_last_idx;

  vrs_decode #(.REG_W(REG_W), .LEN_W(LEN_W), .SP_LG(SP_BANK_LG), .DP_LG(DP_BANK_LG)) u_dec (
    .len_cfg(len_cfg), .stride_cfg(stride_cfg), .dbl_sel(dbl_sel),
    .rd_num(rd_num), .rm_num(rm_num),
    .mode(dec_mode), .illegal(dec_illegal), .last_idx(dec_last_idx), .step_two(dec_step_two)
  );

  logic             valid_q, last_q, illegal_q;
  logic [LEN_W-1:0] cnt_q, last_idx_q;
  logic             dbl_q, step_two_q, hold_m_q;
  logic             accept, fire, load, adv;

  assign accept = start && !valid_q;
  assign fire   = valid_q && ready;
  assign load   = accept && !dec_illegal;
  assign adv    = fire && !last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 1'b0;
      last_q     <= 1'b0;
      illegal_q  <= 1'b0;
      mode_q     <= MODE_SCALAR;
      cnt_q      <= '0;
      last_idx_q <= '0;
      dbl_q      <= 1'b0;
      step_two_q <= 1'b0;
      hold_m_q   <= 1'b0;
    end else begin
      illegal_q <= accept && dec_illegal;
      if (accept) begin
        mode_q <= dec_mode;
        if (!dec_illegal) begin
          valid_q    <= 1'b1;
          cnt_q      <= '0;
          last_q     <= (dec_last_idx == '0);
          last_idx_q <= dec_last_idx;
          dbl_q      <= dbl_sel;
          step_two_q <= dec_step_two;
          hold_m_q   <= (dec_mode == MODE_MIXED);
        end
      end else if (fire) begin
        if (last_q) begin
          valid_q <= 1'b0;
          last_q  <= 1'b0;
        end else begin
          cnt_q  <= cnt_q + LEN_W'(1);
          last_q <= ((cnt_q + LEN_W'(1)) == last_idx_q);
        end
      end
    end
  end

  logic [REG_W-1:0] base_arr [N_IDX];
  logic [REG_W-1:0] idx_arr  [N_IDX];
  logic [N_IDX-1:0] adv_vec;

  assign base_arr[0] = rd_num;
  assign base_arr[1] = rn_num;
  assign base_arr[2] = rm_num;
  assign adv_vec     = {adv && !hold_m_q, adv, adv};

  for (genvar g = 0; g < N_IDX; g++) begin : g_step
    vrs_index_step #(.REG_W(REG_W), .SP_LG(SP_BANK_LG), .DP_LG(DP_BANK_LG)) u_step (
      .clk(clk), .rst(rst), .load(load), .adv(adv_vec[g]),
      .dbl(dbl_q), .step_two(step_two_q),
      .start_num(base_arr[g]), .idx(idx_arr[g])
    );
  end

  assign idx_d       = idx_arr[0];
  assign idx_n       = idx_arr[1];
  assign idx_m       = idx_arr[2];
  assign elem_valid  = valid_q;
  assign elem_last   = last_q;
  assign op_mode     = mode_q;
  assign cfg_illegal = illegal_q;

  // R8
  illegal_no_elem_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_illegal |-> !elem_valid);

  // R11
  last_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && ready && elem_last) |=> !elem_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && !ready) |=> (elem_valid && $stable(idx_d) && $stable(idx_n) && $stable(idx_m)));

  // R3
  mixed_m_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && ready && !elem_last && op_mode == 2'b01) |=> (idx_m == $past(idx_m)));

  // R2
  scalar_single_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && op_mode == 2'b00) |-> elem_last);

  // R10
  busy_mode_chk: assert property (@(posedge clk) disable iff (rst)
    elem_valid |=> $stable(op_mode));
endmodule

// File: tb/vrs_index_seq_test.sv
`timescale 1ns/1ps
module vrs_index_seq_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] len_cfg;
  logic [1:0] stride_cfg;
  logic       dbl_sel;
  logic [4:0] rd_num, rn_num, rm_num;
  logic       start, ready;
  logic [4:0] idx_d, idx_n, idx_m;
  logic       elem_valid, elem_last, cfg_illegal;
  logic [1:0] op_mode;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  vrs_index_seq uut (
    .clk(clk), .rst(rst), .len_cfg(len_cfg), .stride_cfg(stride_cfg), .dbl_sel(dbl_sel),
    .rd_num(rd_num), .rn_num(rn_num), .rm_num(rm_num), .start(start), .ready(ready),
    .idx_d(idx_d), .idx_n(idx_n), .idx_m(idx_m), .elem_valid(elem_valid),
    .elem_last(elem_last), .op_mode(op_mode), .cfg_illegal(cfg_illegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int base, input int i, input int stp, input bit dbl);
    int mask;
    mask = dbl ? 3 : 7;
    return (base & ~mask & 31) | ((base + i * stp) & mask);
  endfunction

  task automatic pulse_start(input int len, input int str, input bit dbl, input int d, input int n, input int m);
    @(negedge clk);
    len_cfg = 3'(len); stride_cfg = 2'(str); dbl_sel = dbl;
    rd_num = 5'(d); rn_num = 5'(n); rm_num = 5'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_seq(input string req, input int len, input int str, input bit dbl,
                         input int d, input int n, input int m, input int mode, input int cnt);
    int stp;
    stp = (str == 3) ? 2 : 1;
    ready = 1'b1;
    pulse_start(len, str, dbl, d, n, m);
    chk({req, " illegal"}, int'(cfg_illegal), 0);
    for (int i = 0; i < cnt; i++) begin
      chk({req, " valid"}, int'(elem_valid), 1);
      chk({req, " mode"}, int'(op_mode), mode);
      chk({req, " d"}, int'(idx_d), exp_idx(d, i, stp, dbl));
      chk({req, " n"}, int'(idx_n), exp_idx(n, i, stp, dbl));
      chk({req, " m"}, int'(idx_m), (mode == 1) ? m : exp_idx(m, i, stp, dbl));
      chk({req, " last"}, int'(elem_last), (i == cnt - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " R11 valid drops"}, int'(elem_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(elem_valid), 0);
    chk("R1 last", int'(elem_last), 0);
    chk("R1 illegal", int'(cfg_illegal), 0);
    chk("R1 mode", int'(op_mode), 0);
    chk("R1 idx", int'({idx_d, idx_n, idx_m}), 0);
  endtask

  task automatic t_scalar;
    run_seq("R2 len0", 0, 0, 0, 10, 20, 5, 0, 1);
    run_seq("R2 fd bank0", 3, 0, 0, 3, 9, 17, 0, 1);
    run_seq("R2 dbl bank4", 1, 0, 1, 18, 9, 13, 0, 1);
    run_seq("R8 scalar rsvd stride ok", 0, 1, 0, 12, 20, 28, 0, 1);
  endtask

  task automatic t_vector;
    run_seq("R4 R6 wrap s13", 5, 0, 0, 13, 21, 29, 2, 6);
    run_seq("R6 stride2 s8", 3, 3, 0, 8, 9, 25, 2, 4);
    run_seq("R5 full bank", 7, 0, 0, 24, 16, 8, 2, 8);
  endtask

  task automatic t_mixed;
    run_seq("R3 mixed", 3, 0, 0, 16, 24, 2, 1, 4);
  endtask

  task automatic t_double;
    run_seq("R7 d5 wrap", 3, 0, 1, 5, 9, 13, 2, 4);
    run_seq("R7 d stride2", 1, 3, 1, 21, 26, 30, 2, 2);
  endtask

  task automatic t_illegal(input string req, input int len, input int str, input bit dbl, input int d, input int m);
    ready = 1'b1;
    pulse_start(len, str, dbl, d, 9, m);
    chk({req, " pulse"}, int'(cfg_illegal), 1);
    chk({req, " no valid"}, int'(elem_valid), 0);
    @(negedge clk);
    chk({req, " pulse ends"}, int'(cfg_illegal), 0);
    chk({req, " still no valid"}, int'(elem_valid), 0);
  endtask

  task automatic t_stall;
    ready = 1'b0;
    pulse_start(2, 0, 0, 10, 18, 26);
    chk("R11 first elem", int'(elem_valid), 1);
    @(negedge clk);
    chk("R9 hold valid", int'(elem_valid), 1);
    chk("R9 hold d", int'(idx_d), 10);
    chk("R9 hold m", int'(idx_m), 26);
    len_cfg = 3'd0; rd_num = 5'd1; rn_num = 5'd2; rm_num = 5'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy start d", int'(idx_d), 10);
    chk("R10 busy start mode", int'(op_mode), 2);
    chk("R10 busy last", int'(elem_last), 0);
    ready = 1'b1;
    @(negedge clk);
    chk("R10 continues d", int'(idx_d), 11);
    chk("R10 continues n", int'(idx_n), 19);
    @(negedge clk);
    chk("R5 third d", int'(idx_d), 12);
    chk("R5 third last", int'(elem_last), 1);
    @(negedge clk);
    chk("R11 end", int'(elem_valid), 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; ready = 1'b0;
    len_cfg = '0; stride_cfg = '0; dbl_sel = 1'b0;
    rd_num = '0; rn_num = '0; rm_num = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_scalar();
    t_vector();
    t_mixed();
    t_double();
    t_illegal("R8 stride 01", 1, 1, 0, 8, 16);
    t_illegal("R8 stride 10", 1, 2, 0, 8, 16);
    t_illegal("R8 span s", 4, 3, 0, 8, 16);
    t_illegal("R8 span d", 4, 0, 1, 5, 9);
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule